// File: doc/BRIEF.md
# Address-Tweaked Block Whitening Unit

This unit prepares 128-bit data blocks for an external-flash encryption path. Each block is four 32-bit words. Every word is XORed with its own address-derived value, so identical plaintext stored at different flash locations no longer yields identical cipher input. The unit first clears the low four bits of the byte address to get a 16-byte-aligned base. The four lane masks are then base, base+4, base+8 and base+12. The whitened block goes out through a valid/ready handshake toward a block-cipher stage, such as an AES-128 ECB core. It is tagged with its aligned address and with a direction flag.

The same XOR also undoes the whitening on the return path: a block that has just been decrypted is passed back through the unit with the same address. The direction flag only tells the downstream logic which way the data is travelling. It never changes the arithmetic.

Data enters in one of two ways. A single 128-bit beat can be given together with its address. Alternatively, an address write is followed by four separate 32-bit word writes; the block is emitted once the fourth word arrives. The output stage holds one block. While that block waits for the consumer, no new input is taken.

Top module: `addr_whiten_unit`

## Requirements
- R1: `out_addr` equals the accepted address with bits [3:0] cleared to zero.
- R2: `out_block` equals the input block XORed with {base, base+4, base+8, base+12}, where word0 occupies bits [127:96] and word3 occupies bits [31:0].
- R3: Lane offsets are added modulo 2^32 and never raise an error. The topmost aligned block, base 0xFFFFFFF0, uses the masks 0xFFFFFFF0, 0xFFFFFFF4, 0xFFFFFFF8 and 0xFFFFFFFC.
- R4: A beat is accepted on a clock edge where `in_valid` and `in_ready` are both high. `out_valid` rises in the following cycle.
- R5: `addr_wr` latches `addr_val` as the serial base and resets the word count to 0. The serial words fill word0 first, then word1, word2 and word3. The edge that accepts the fourth word makes `out_valid` high in the next cycle.
- R6: When `addr_wr` and `word_wr` are high in the same cycle, the new address applies and the word is stored as word0.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_block`, `out_addr` and `out_dir` stay unchanged.
- R8: `in_ready` is the inverse of `out_valid`. Beats and word writes offered while a block is pending are ignored: they neither alter the pending block nor advance the word count.
- R9: `out_dir` carries the `in_dir` value sampled when the beat or the fourth word is accepted (0 means whiten, 1 means unwhiten). The data result is the same for both values.
- R10: When a beat and a word write are offered together, the beat is taken and the word write is dropped without advancing the word count.
- R11: A synchronous active-low reset clears the pending output, the word count and the latched serial base (to 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_dir | input | 1 | 0 = whiten before cipher, 1 = unwhiten after decryption |
| in_valid | input | 1 | 128-bit beat offered |
| in_ready | output | 1 | Unit can accept a beat or word write |
| in_addr | input | 32 | Byte address of the beat |
| in_block | input | 128 | Beat data, word0 in the top bits |
| addr_wr | input | 1 | Serial address write strobe |
| addr_val | input | 32 | Serial byte address |
| word_wr | input | 1 | Serial word write strobe |
| word_val | input | 32 | Serial word data |
| out_valid | output | 1 | Whitened block available |
| out_ready | input | 1 | Consumer takes the block |
| out_block | output | 128 | Whitened block |
| out_addr | output | 32 | 16-byte-aligned address tag |
| out_dir | output | 1 | Direction tag of the block |

## Verification
The assertions treat `out_ready` as a plain level that may change in any cycle. They assume reset is held low across at least one clock edge. They also assume the word count is a power of two, so the serial counter wraps naturally. They do not require the producer to keep strobes away from a full buffer. The stimulus deliberately offers beats and word writes while a block is pending, and together in one cycle, to show that such input is dropped. All inputs change on the falling clock edge, so every strobe is seen on exactly one rising edge.

// File: rtl/awu_pkg.sv
// Package: shared types and helpers for the address whitening unit.
// Assumes: word and block widths are whole bytes.
package awu_pkg;

    // Direction tag travelling with every block.
    typedef enum logic {
        AWU_FWD = 1'b0,
        AWU_REV = 1'b1
    } awu_dir_e;

    // Number of low address bits cleared to align on one block.
    function automatic int unsigned align_bits(input int unsigned n_words,
                                               input int unsigned word_w);
        return $clog2((n_words * word_w) / 8);
    endfunction

endpackage

// File: rtl/awu_mask_gen.sv
// Module: awu_mask_gen
// Builds the block-aligned base from a byte address. From it, builds one
// mask word per lane: base + lane*bytes_per_word, with lane 0 in the most
// significant position. Purely combinational.
// Assumes: address width equals word width; sums wrap modulo 2^WORD_W.
module awu_mask_gen #(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned N_WORDS = 4
) (
    input  logic [WORD_W-1:0]         addr_in,
    output logic [WORD_W-1:0]         base_out,
    output logic [N_WORDS*WORD_W-1:0] mask_out
);
    localparam int unsigned ALIGN  = awu_pkg::align_bits(N_WORDS, WORD_W);
    localparam int unsigned STRIDE = WORD_W / 8;

    // Clear the in-block offset bits.
    assign base_out = {addr_in[WORD_W-1:ALIGN], {ALIGN{1'b0}}};

    // One adder per lane; lane g sits at the g-th word from the top.
    for (genvar g = 0; g < N_WORDS; g++) begin : g_lane
        assign mask_out[(N_WORDS-1-g)*WORD_W +: WORD_W] =
            base_out + WORD_W'(g * STRIDE);
    end

endmodule

// File: rtl/awu_word_collect.sv
// Module: awu_word_collect
// Assembles a block from serial word writes. An address write latches the
// base and restarts the count. When an address write and a word write come
// in the same cycle, the word lands in lane 0. last_o marks the cycle that
// completes the block; block_o then shows the full block, new word included.
// Assumes: word_go is already qualified by the caller; N_WORDS is a power of 2.
module awu_word_collect #(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned N_WORDS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      addr_wr,
    input  logic [WORD_W-1:0]         addr_val,
    input  logic                      word_go,
    input  logic [WORD_W-1:0]         word_val,
    output logic [WORD_W-1:0]         base_o,
    output logic [N_WORDS*WORD_W-1:0] block_o,
    output logic                      last_o
);
    localparam int unsigned CNT_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(N_WORDS - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_eff;
    logic [WORD_W-1:0] base_q;
    logic [WORD_W-1:0] lanes_q [N_WORDS];

    // Effective count and base: an address write this cycle takes effect at once.
    always_comb begin
        cnt_eff = addr_wr ? '0 : cnt_q;
        base_o  = addr_wr ? addr_val : base_q;
        last_o  = word_go && (cnt_eff == LAST);
    end

    // Latch the serial base and step the word counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            base_q <= '0;
        end else begin
            if (addr_wr) begin
                base_q <= addr_val;
            end
            if (word_go) begin
                cnt_q <= (cnt_eff == LAST) ? '0 : cnt_eff + 1'b1;
            end else if (addr_wr) begin
                cnt_q <= '0;
            end
        end
    end

    // Word storage; data only, so no reset is needed.
    always_ff @(posedge clk) begin
        if (word_go) begin
            lanes_q[cnt_eff] <= word_val;
        end
    end

    // Present stored lanes, with the arriving word substituted in its slot.
    for (genvar g = 0; g < N_WORDS; g++) begin : g_asm
        assign block_o[(N_WORDS-1-g)*WORD_W +: WORD_W] =
            (word_go && (cnt_eff == CNT_W'(g))) ? word_val : lanes_q[g];
    end

    // R5: an address write without a word leaves the count at zero.
    a_r5_addr_restarts_count: assert property (@(posedge clk) disable iff (!rst_n)
        addr_wr && !word_go |=> cnt_q == '0);

    // R5/R6: a non-final word moves the count one past the slot it used.
    a_r5_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        word_go && !last_o |=> cnt_q == $past(cnt_eff) + 1'b1);

    // R11: reset leaves the count and base at zero.
    a_r11_collect_reset: assert property (@(posedge clk)
        !rst_n |=> cnt_q == '0 && base_q == '0);

endmodule

// File: rtl/awu_out_reg.sv
// Module: awu_out_reg
// Single-entry output holding register with a valid/ready handshake.
// Loads a block when empty and keeps it until the consumer takes it.
// Assumes: the caller raises load only while free_o is high.
module awu_out_reg #(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned N_WORDS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [N_WORDS*WORD_W-1:0] ld_block,
    input  logic [WORD_W-1:0]         ld_addr,
    input  awu_pkg::awu_dir_e         ld_dir,
    input  logic                      out_ready,
    output logic                      free_o,
    output logic                      out_valid,
    output logic [N_WORDS*WORD_W-1:0] out_block,
    output logic [WORD_W-1:0]         out_addr,
    output awu_pkg::awu_dir_e         out_dir
);
    localparam int unsigned ALIGN = awu_pkg::align_bits(N_WORDS, WORD_W);

    // Empty whenever nothing is pending.
    assign free_o = !out_valid;

    // Pending flag: set on load, cleared when the consumer takes the block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Payload capture; only written on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_block <= '0;
            out_addr  <= '0;
            out_dir   <= awu_pkg::AWU_FWD;
        end else if (load) begin
            out_block <= ld_block;
            out_addr  <= ld_addr;
            out_dir   <= ld_dir;
        end
    end

    // R7: a stalled block is held with all tags.
    a_r7_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_block)
                                    && $stable(out_addr) && $stable(out_dir));

    // R8: nothing is loaded over a pending block.
    a_r8_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !out_valid);

    // R4: a load makes the block visible in the next cycle.
    a_r4_load_shows_valid: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> out_valid);

    // R1: any presented address tag is block aligned.
    a_r1_tag_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_addr[ALIGN-1:0] == '0);

    // R11: reset empties the buffer.
    a_r11_out_reset: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

endmodule

// File: rtl/addr_whiten_unit.sv
// Module: addr_whiten_unit (top)
// Whitens a 128-bit block by XORing each 32-bit lane with a mask derived
// from the block-aligned address. Takes either a full beat or an address
// write plus serial word writes. Emits through a one-entry valid/ready
// buffer. The same operation undoes the whitening; in_dir only tags the block.
// Assumes: a beat has priority over a word write in the same cycle.
module addr_whiten_unit #(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned N_WORDS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_dir,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [WORD_W-1:0]         in_addr,
    input  logic [N_WORDS*WORD_W-1:0] in_block,
    input  logic                      addr_wr,
    input  logic [WORD_W-1:0]         addr_val,
    input  logic                      word_wr,
    input  logic [WORD_W-1:0]         word_val,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [N_WORDS*WORD_W-1:0] out_block,
    output logic [WORD_W-1:0]         out_addr,
    output logic                      out_dir
);
    localparam int unsigned BLK_W = N_WORDS * WORD_W;

    logic               free;
    logic               beat_go;
    logic               word_go;
    logic [WORD_W-1:0]  col_base;
    logic [BLK_W-1:0]   col_block;
    logic               col_last;
    logic [WORD_W-1:0]  src_addr;
    logic [BLK_W-1:0]   src_block;
    logic [WORD_W-1:0]  aligned;
    logic [BLK_W-1:0]   mask;
    logic               load;
    awu_pkg::awu_dir_e  dir_sel;
    awu_pkg::awu_dir_e  dir_held;

    // Accept rules: the beat wins; words only when empty and no beat.
    always_comb begin
        beat_go = in_valid && free;
        word_go = word_wr && free && !in_valid;
        dir_sel = awu_pkg::awu_dir_e'(in_dir);
    end

    assign in_ready = free;

    awu_word_collect #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_collect (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_wr  (addr_wr),
        .addr_val (addr_val),
        .word_go  (word_go),
        .word_val (word_val),
        .base_o   (col_base),
        .block_o  (col_block),
        .last_o   (col_last)
    );

    // Select the source of the block being loaded this cycle.
    always_comb begin
        src_addr  = beat_go ? in_addr  : col_base;
        src_block = beat_go ? in_block : col_block;
        load      = beat_go || col_last;
    end

    awu_mask_gen #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_mask (
        .addr_in  (src_addr),
        .base_out (aligned),
        .mask_out (mask)
    );

    awu_out_reg #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .ld_block  (src_block ^ mask),
        .ld_addr   (aligned),
        .ld_dir    (dir_sel),
        .out_ready (out_ready),
        .free_o    (free),
        .out_valid (out_valid),
        .out_block (out_block),
        .out_addr  (out_addr),
        .out_dir   (dir_held)
    );

    assign out_dir = logic'(dir_held);

    // R5: completing the serial block produces an output next cycle.
    a_r5_fourth_word_emits: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |=> out_valid);

    // R8: the ready signal never shows room while a block is pending.
    a_r8_ready_vs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R9: an accepted beat carries its direction to the output.
    a_r9_dir_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_dir == $past(in_dir));

    // R10: a beat and a word together yield the beat, never the serial block.
    a_r10_beat_priority: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && word_wr |-> !col_last);

endmodule

// File: tb/addr_whiten_unit_bench.sv
module addr_whiten_unit_bench;

    typedef struct packed {
        logic [31:0]  addr;
        logic [127:0] blk;
        logic         dir;
        logic [31:0]  exp_addr;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 128'h0, 1'b0, 32'h0000_0000},
        '{32'h1234_5678, 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF, 1'b0, 32'h1234_5670},
        '{32'hFFFF_FFFF, {128{1'b1}}, 1'b1, 32'hFFFF_FFF0},
        '{32'h0000_000F, 128'hDEAD_BEEF_CAFE_F00D_0BAD_C0DE_1234_ABCD, 1'b1, 32'h0000_0000},
        '{32'h8000_0010, 128'h0F0F_0F0F_F0F0_F0F0_5555_5555_AAAA_AAAA, 1'b0, 32'h8000_0010},
        '{32'hABCD_EF07, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 1'b1, 32'hABCD_EF00}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_dir = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [31:0]  in_addr = '0;
    logic [127:0] in_block = '0;
    logic         addr_wr = 1'b0;
    logic [31:0]  addr_val = '0;
    logic         word_wr = 1'b0;
    logic [31:0]  word_val = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [127:0] out_block;
    logic [31:0]  out_addr;
    logic         out_dir;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    addr_whiten_unit u_addr_whiten_unit (
        .clk(clk), .rst_n(rst_n), .in_dir(in_dir), .in_valid(in_valid),
        .in_ready(in_ready), .in_addr(in_addr), .in_block(in_block),
        .addr_wr(addr_wr), .addr_val(addr_val), .word_wr(word_wr),
        .word_val(word_val), .out_valid(out_valid), .out_ready(out_ready),
        .out_block(out_block), .out_addr(out_addr), .out_dir(out_dir)
    );

    function automatic logic [127:0] expect_blk(input logic [31:0] a, input logic [127:0] b);
        logic [31:0] base;
        base = a & 32'hFFFF_FFF0;
        return b ^ {base, base + 32'd4, base + 32'd8, base + 32'd12};
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Each task starts just after a falling edge and ends on one.
    task automatic beat(input logic [31:0] a, input logic [127:0] b, input logic d);
        in_valid = 1'b1; in_addr = a; in_block = b; in_dir = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wr_addr(input logic [31:0] a);
        addr_wr = 1'b1; addr_val = a;
        @(negedge clk);
        addr_wr = 1'b0;
    endtask

    task automatic wr_word(input logic [31:0] w, input logic d);
        word_wr = 1'b1; word_val = w; in_dir = d;
        @(negedge clk);
        word_wr = 1'b0;
    endtask

    task automatic pop();
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] first;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 reset out_valid", 128'(out_valid), 128'd0);
        chk("R8 reset in_ready", 128'(in_ready), 128'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1 R2 R3 R4 R9
        for (int i = 0; i < NV; i++) begin
            beat(VECS[i].addr, VECS[i].blk, VECS[i].dir);
            chk("R4 valid after beat", 128'(out_valid), 128'd1);
            chk("R2 block", out_block, expect_blk(VECS[i].addr, VECS[i].blk));
            chk("R1 addr", 128'(out_addr), 128'(VECS[i].exp_addr));
            chk("R9 dir", 128'(out_dir), 128'(VECS[i].dir));
            pop();
            chk("R4 drained", 128'(out_valid), 128'd0);
        end

        // R3: explicit top-of-space masks
        beat(32'hFFFF_FFF4, 128'h0, 1'b0);
        chk("R3 wrap masks", out_block, 128'hFFFF_FFF0_FFFF_FFF4_FFFF_FFF8_FFFF_FFFC);
        pop();

        // R9: direction does not alter data
        beat(32'h0000_1234, 128'h5A5A, 1'b1);
        first = out_block;
        pop();
        beat(32'h0000_1234, 128'h5A5A, 1'b0);
        chk("R9 same data both dirs", out_block, first);
        pop();

        // R7 / R8: stall, offered beat ignored
        beat(32'h0000_2000, 128'h1111, 1'b0);
        first = out_block;
        repeat (3) @(negedge clk);
        chk("R7 held valid", 128'(out_valid), 128'd1);
        chk("R7 held block", out_block, first);
        chk("R8 ready low", 128'(in_ready), 128'd0);
        beat(32'h0000_3000, 128'h2222, 1'b1);
        chk("R8 ignored beat block", out_block, first);
        chk("R8 ignored beat dir", 128'(out_dir), 128'd0);
        pop();
        chk("R8 ignored beat not queued", 128'(out_valid), 128'd0);

        // R5: serial path
        wr_addr(32'h0000_4008);
        wr_word(32'hA0A0_A0A0, 1'b0);
        wr_word(32'hB1B1_B1B1, 1'b0);
        wr_word(32'hC2C2_C2C2, 1'b0);
        chk("R5 not early", 128'(out_valid), 128'd0);
        wr_word(32'hD3D3_D3D3, 1'b1);
        chk("R5 valid after fourth", 128'(out_valid), 128'd1);
        chk("R5 block", out_block, expect_blk(32'h0000_4000,
            128'hA0A0_A0A0_B1B1_B1B1_C2C2_C2C2_D3D3_D3D3));
        chk("R5 addr", 128'(out_addr), 128'h4000);
        chk("R9 serial dir", 128'(out_dir), 128'd1);
        pop();

        // R5: address write mid-sequence restarts the count
        wr_addr(32'h0000_5000);
        wr_word(32'h1, 1'b0);
        wr_word(32'h2, 1'b0);
        wr_addr(32'h0000_6010);
        wr_word(32'h3, 1'b0);
        wr_word(32'h4, 1'b0);
        wr_word(32'h5, 1'b0);
        chk("R5 restart not early", 128'(out_valid), 128'd0);
        wr_word(32'h6, 1'b0);
        chk("R5 restart block", out_block, expect_blk(32'h0000_6010,
            {32'h3, 32'h4, 32'h5, 32'h6}));
        pop();

        // R6: address and word in one cycle
        addr_wr = 1'b1; addr_val = 32'h0000_7004;
        word_wr = 1'b1; word_val = 32'hEEEE_0000;
        @(negedge clk);
        addr_wr = 1'b0; word_wr = 1'b0;
        wr_word(32'hEEEE_0001, 1'b0);
        wr_word(32'hEEEE_0002, 1'b0);
        wr_word(32'hEEEE_0003, 1'b0);
        chk("R6 block", out_block, expect_blk(32'h0000_7000,
            128'hEEEE_0000_EEEE_0001_EEEE_0002_EEEE_0003));
        pop();

        // R8: word write while pending does not advance the count
        wr_addr(32'h0000_8000);
        wr_word(32'h10, 1'b0);
        beat(32'h0000_9000, 128'h77, 1'b0);
        wr_word(32'hBAD, 1'b0);
        chk("R8 pending block kept", out_block, expect_blk(32'h0000_9000, 128'h77));
        pop();
        wr_word(32'h11, 1'b0);
        wr_word(32'h12, 1'b0);
        wr_word(32'h13, 1'b0);
        chk("R8 word ignored", out_block, expect_blk(32'h0000_8000,
            {32'h10, 32'h11, 32'h12, 32'h13}));
        pop();

        // R10: beat and word together, beat wins, count untouched
        wr_addr(32'h0000_A000);
        in_valid = 1'b1; in_addr = 32'h0000_B000; in_block = 128'h99; in_dir = 1'b0;
        word_wr = 1'b1; word_val = 32'hDEAD;
        @(negedge clk);
        in_valid = 1'b0; word_wr = 1'b0;
        chk("R10 beat taken", out_block, expect_blk(32'h0000_B000, 128'h99));
        pop();
        wr_word(32'h20, 1'b0);
        wr_word(32'h21, 1'b0);
        wr_word(32'h22, 1'b0);
        wr_word(32'h23, 1'b0);
        chk("R10 word dropped", out_block, expect_blk(32'h0000_A000,
            {32'h20, 32'h21, 32'h22, 32'h23}));
        pop();

        // R11: reset mid-sequence clears base and count; reset drops pending
        wr_addr(32'h0000_C000);
        wr_word(32'h30, 1'b0);
        wr_word(32'h31, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        wr_word(32'h40, 1'b0);
        wr_word(32'h41, 1'b0);
        wr_word(32'h42, 1'b0);
        wr_word(32'h43, 1'b0);
        chk("R11 base and count cleared", out_block, expect_blk(32'h0,
            {32'h40, 32'h41, 32'h42, 32'h43}));
        chk("R11 base addr", 128'(out_addr), 128'd0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R11 pending cleared", 128'(out_valid), 128'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule